// File: doc/BRIEF.md
# Regulator Start-Up and Protection Sequencer

This block supervises a multi-phase buck regulator. Analog comparators outside it resolve the bias-supply good level, the enable threshold, the frequency-select/disable pin, over-current, over-voltage and under-voltage into digital levels. From those levels the block decides when the power stage may switch. It walks a digital soft-start ramp on each phase-clock tick. It hands the regulation loop a reference that is the lower of the ramp and the value set by the 5-bit voltage code. It also drives the per-phase output-enable and the crowbar controls.

A fault on current causes a hiccup: switching stops for a few phase-clock ticks, then a fresh soft-start begins. After a set number of such events the block locks out. An over-voltage event crowbars the output by forcing every low-side switch on and raising the protection pin. Both latches clear only when bias power goes away. Power-good is raised only once the ramp has finished and the output sits between the under- and over-voltage limits.

Top module: `vr_sequencer`

## Requirements
- R1: Switching (pwm_oe_o = 1) begins, from shutdown, the cycle after por_ok_i, en_i and fs_ok_i are all 1 and vid_i is not 5'b11111; with any of them missing the block stays in shutdown.
- R2: In shutdown, hiccup and lockout, pwm_oe_o = 0 and every lowside_on_o bit is 0.
- R3: Soft-start counts SS_BITS-wide (default 2048) phase-clock ticks; the count advances only on cycles with tick_i = 1, and the block enters run on the tick after the count reaches its all-ones value.
- R4: ramp_o, in units of 0.2 mV, equals floor(ref_mv * 7 * n / 2048) during soft-start, where n is the current tick count; it equals ref_mv * 7 (140 % of reference) in run and 0 otherwise.
- R5: target_o always equals the smaller of ramp_o and ref_mv * 5 (the reference in 0.2 mV units).
- R6: ref_mv = 1550 - 25 * vid_i (code 0 gives 1.550 V, code 30 gives 0.800 V); code 31 forces shutdown, and any other code afterwards starts soft-start from count zero.
- R7: Dropping en_i or fs_ok_i returns the block to shutdown the next cycle; restoring it restarts soft-start from count zero.
- R8: oc_i = 1 during soft-start or run stops switching for HIC_TICKS phase-clock ticks and then restarts soft-start from zero; the RETRY_MAX-th such event since bias-good locks out (lockout_o = 1) until por_ok_i falls.
- R9: ov_i = 1 with por_ok_i = 1 sets ovp_o and all lowside_on_o bits and clears pwm_oe_o the next cycle; this state holds regardless of other inputs until por_ok_i falls.
- R10: pgood_o = 1 only in run with uv_i = 0 and ov_i = 0; uv_i does not stop switching.
- R11: por_ok_i = 0 clears the over-voltage latch, the lockout and the retry count on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| por_ok_i | input | 1 | Bias supply above power-on threshold |
| en_i | input | 1 | Enable comparator output |
| fs_ok_i | input | 1 | Frequency-select pin not grounded |
| vid_i | input | 5 | Voltage code |
| tick_i | input | 1 | Phase-clock pulse, one cycle wide |
| oc_i | input | 1 | Over-current comparator |
| ov_i | input | 1 | Over-voltage comparator |
| uv_i | input | 1 | Under-voltage comparator |
| pwm_oe_o | output | 1 | Drive enable for all PWM outputs (0 = high impedance) |
| lowside_on_o | output | N_PHASES | Force low-side switch on, per phase |
| ovp_o | output | 1 | Latched over-voltage crowbar drive |
| pgood_o | output | 1 | Power good |
| lockout_o | output | 1 | Latched off after repeated over-current |
| ramp_o | output | 14 | Soft-start ramp, 0.2 mV units |
| target_o | output | 14 | Regulation target, 0.2 mV units |

## Verification
The ramp is walked once with a tick every other cycle and several times with a tick every cycle, so counting clocks instead of ticks would show up. Each full ramp crosses the point where the 140 % ramp overtakes the reference, which separates a min selection from either input. The voltage code is changed mid-ramp and to the reserved value. The enable and the frequency-select pin are dropped with the phase clock stopped, which tells a fresh restart from a resumed one. Over-current events are spaced to walk the retry count up to lockout, and over-voltage is raised and released to show the latch surviving an enable drop but not a bias drop.

// File: rtl/vrs_pkg.sv
package vrs_pkg;
  localparam int VID_W     = 5;
  localparam int REF_W     = 11;
  localparam int VMAX_MV   = 1550;
  localparam int VSTEP_MV  = 25;

  typedef enum logic [2:0] {
    ST_OFF, ST_SOFT, ST_RUN, ST_HIC, ST_LOCK, ST_OV
  } vrs_state_e;
endpackage

// File: rtl/vrs_counter.sv
module vrs_counter #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (inc_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/vrs_ramp.sv
module vrs_ramp
  import vrs_pkg::*;
#(
  parameter int SS_BITS = 11,
  parameter int OUT_W   = REF_W + 3
) (
  input  logic [VID_W-1:0] vid_i,
  input  logic [SS_BITS:0] idx_i,
  output logic [OUT_W-1:0] ramp_o,
  output logic [OUT_W-1:0] target_o
);
  localparam int PROD_W = REF_W + 3 + SS_BITS + 1;

  logic [REF_W-1:0]  ref_mv;
  logic [PROD_W-1:0] prod;
  logic [OUT_W-1:0]  ref5;

  always_comb begin
    ref_mv   = REF_W'(VMAX_MV - VSTEP_MV * int'(vid_i));
    prod     = PROD_W'(ref_mv) * PROD_W'(7) * PROD_W'(idx_i);
    ramp_o   = OUT_W'(prod >> SS_BITS);
    ref5     = OUT_W'(ref_mv) * OUT_W'(5);
    target_o = (ramp_o < ref5) ? ramp_o : ref5;
  end
endmodule

// File: rtl/vr_sequencer.sv
module vr_sequencer
  import vrs_pkg::*;
#(
  parameter int N_PHASES  = 4,
  parameter int SS_BITS   = 11,
  parameter int RETRY_MAX = 3,
  parameter int HIC_TICKS = 4,
  localparam int OUT_W    = REF_W + 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                por_ok_i,
  input  logic                en_i,
  input  logic                fs_ok_i,
  input  logic [VID_W-1:0]    vid_i,
  input  logic                tick_i,
  input  logic                oc_i,
  input  logic                ov_i,
  input  logic                uv_i,
  output logic                pwm_oe_o,
  output logic [N_PHASES-1:0] lowside_on_o,
  output logic                ovp_o,
  output logic                pgood_o,
  output logic                lockout_o,
  output logic [OUT_W-1:0]    ramp_o,
  output logic [OUT_W-1:0]    target_o
);
  localparam int RT_W  = $clog2(RETRY_MAX + 1);
  localparam int HIC_W = $clog2(HIC_TICKS + 1);

  vrs_state_e        state_q, state_d;
  logic [RT_W-1:0]   retry_q, retry_d;
  logic [SS_BITS-1:0] ss_cnt;
  logic [HIC_W-1:0]  hic_cnt;
  logic              run_ok, ss_clr, ss_inc, hic_clr, hic_inc;
  logic [SS_BITS:0]  ramp_idx;

  assign run_ok = por_ok_i & en_i & fs_ok_i & (vid_i != '1);

  always_comb begin
    state_d = state_q;
    retry_d = retry_q;
    if (!por_ok_i) begin
      state_d = ST_OFF;
      retry_d = '0;
    end else if (state_q == ST_OV) begin
      state_d = ST_OV;
    end else if (ov_i) begin
      state_d = ST_OV;
    end else if (state_q == ST_LOCK) begin
      state_d = ST_LOCK;
    end else if (!run_ok) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF: state_d = ST_SOFT;
        ST_SOFT, ST_RUN: begin
          if (oc_i) begin
            if (int'(retry_q) == RETRY_MAX - 1) state_d = ST_LOCK;
            else begin
              state_d = ST_HIC;
              retry_d = retry_q + 1'b1;
            end
          end else if (state_q == ST_SOFT && tick_i && (&ss_cnt)) begin
            state_d = ST_RUN;
          end
        end
        ST_HIC: if (tick_i && int'(hic_cnt) == HIC_TICKS - 1) state_d = ST_SOFT;
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      retry_q <= '0;
    end else begin
      state_q <= state_d;
      retry_q <= retry_d;
    end
  end

  // fresh ramp on every entry into soft-start
  assign ss_clr  = (state_d == ST_OFF) || (state_d == ST_SOFT && state_q != ST_SOFT);
  assign ss_inc  = (state_q == ST_SOFT) && (state_d == ST_SOFT) && tick_i;
  assign hic_clr = (state_d != ST_HIC) || (state_q != ST_HIC);
  assign hic_inc = (state_q == ST_HIC) && tick_i;

  vrs_counter #(.W(SS_BITS)) u_ss_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(ss_clr), .inc_i(ss_inc), .cnt_o(ss_cnt)
  );

  vrs_counter #(.W(HIC_W)) u_hic_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(hic_clr), .inc_i(hic_inc), .cnt_o(hic_cnt)
  );

  always_comb begin
    unique case (state_q)
      ST_SOFT: ramp_idx = {1'b0, ss_cnt};
      ST_RUN:  ramp_idx = {1'b1, {SS_BITS{1'b0}}};
      default: ramp_idx = '0;
    endcase
  end

  vrs_ramp #(.SS_BITS(SS_BITS), .OUT_W(OUT_W)) u_ramp (
    .vid_i(vid_i), .idx_i(ramp_idx), .ramp_o(ramp_o), .target_o(target_o)
  );

  assign pwm_oe_o  = (state_q == ST_SOFT) || (state_q == ST_RUN);
  assign ovp_o     = (state_q == ST_OV);
  assign lockout_o = (state_q == ST_LOCK);
  assign pgood_o   = (state_q == ST_RUN) && !uv_i && !ov_i;

  for (genvar p = 0; p < N_PHASES; p++) begin : g_phase
    assign lowside_on_o[p] = (state_q == ST_OV);
  end
endmodule

// File: rtl/vr_sequencer_chk.sv
module vr_sequencer_chk #(
  parameter int N_PHASES = 4,
  parameter int OUT_W    = 14
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                por_ok_i,
  input logic                en_i,
  input logic                fs_ok_i,
  input logic [4:0]          vid_i,
  input logic                ov_i,
  input logic                uv_i,
  input logic                pwm_oe_o,
  input logic [N_PHASES-1:0] lowside_on_o,
  input logic                ovp_o,
  input logic                pgood_o,
  input logic                lockout_o,
  input logic [OUT_W-1:0]    ramp_o,
  input logic [OUT_W-1:0]    target_o
);
  assert_gate_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || !fs_ok_i) |=> !pwm_oe_o);

  assert_por_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !por_ok_i |=> (!pwm_oe_o && !ovp_o && !lockout_o));

  assert_lock_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lockout_o |-> (!pwm_oe_o && lowside_on_o == '0));

  assert_target_min_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    target_o <= ramp_o);

  assert_reserved_vid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vid_i == 5'h1f) |=> !pwm_oe_o);

  assert_lock_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lockout_o && por_ok_i && !ov_i) |=> lockout_o);

  assert_ov_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_ok_i && ov_i) |=> (ovp_o && (&lowside_on_o) && !pwm_oe_o));

  assert_ov_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_ok_i && ovp_o) |=> ovp_o);

  assert_pgood_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgood_o |-> (pwm_oe_o && !uv_i && !ov_i));
endmodule

bind vr_sequencer vr_sequencer_chk #(.N_PHASES(N_PHASES), .OUT_W(OUT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .por_ok_i(por_ok_i), .en_i(en_i),
  .fs_ok_i(fs_ok_i), .vid_i(vid_i), .ov_i(ov_i), .uv_i(uv_i),
  .pwm_oe_o(pwm_oe_o), .lowside_on_o(lowside_on_o), .ovp_o(ovp_o),
  .pgood_o(pgood_o), .lockout_o(lockout_o), .ramp_o(ramp_o), .target_o(target_o)
);

// File: tb/vr_sequencer_test.sv
module vr_sequencer_test;
  localparam int NPH = 4;
  localparam int SSN = 2048;
  localparam int RETRIES = 3;
  localparam int HICN = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por = 0, en = 0, fs = 0, tick = 0, oc = 0, ov = 0, uv = 0;
  logic [4:0] vid = 5'd0;
  logic pwm_oe, ovp, pgood, lockout;
  logic [NPH-1:0] lowside;
  logic [13:0] ramp, target;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  // reference model state: 0 off, 1 soft, 2 run, 3 hiccup, 4 lockout, 5 overvoltage
  int m_st = 0, m_ss = 0, m_hic = 0, m_retry = 0;

  always #2 clk = ~clk;

  vr_sequencer #(.N_PHASES(NPH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .por_ok_i(por), .en_i(en), .fs_ok_i(fs),
    .vid_i(vid), .tick_i(tick), .oc_i(oc), .ov_i(ov), .uv_i(uv),
    .pwm_oe_o(pwm_oe), .lowside_on_o(lowside), .ovp_o(ovp), .pgood_o(pgood),
    .lockout_o(lockout), .ramp_o(ramp), .target_o(target)
  );

  function automatic int ref_mv(input int code);
    return 1550 - 25 * code;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_st = 0; m_ss = 0; m_hic = 0; m_retry = 0;
    end else if (!por) begin
      m_st = 0; m_ss = 0; m_retry = 0;
    end else if (m_st == 5) begin
      m_st = 5;
    end else if (ov) begin
      m_st = 5;
    end else if (m_st == 4) begin
      m_st = 4;
    end else if (!(en && fs && vid != 5'd31)) begin
      m_st = 0; m_ss = 0;
    end else if (m_st == 0) begin
      m_st = 1; m_ss = 0;
    end else if ((m_st == 1 || m_st == 2) && oc) begin
      if (m_retry + 1 >= RETRIES) m_st = 4;
      else begin m_retry++; m_st = 3; m_hic = 0; end
    end else if (m_st == 1) begin
      if (tick) begin
        if (m_ss == SSN - 1) m_st = 2;
        else m_ss++;
      end
    end else if (m_st == 3) begin
      if (tick) begin
        m_hic++;
        if (m_hic == HICN) begin m_st = 1; m_ss = 0; end
      end
    end
  end

  // compare one ns after each edge, before the next input change
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      int n, rr, r5, tg;
      n  = (m_st == 1) ? m_ss : (m_st == 2) ? SSN : 0;
      rr = (ref_mv(int'(vid)) * 7 * n) / SSN;
      r5 = ref_mv(int'(vid)) * 5;
      tg = (rr < r5) ? rr : r5;
      chk("R1/R2 pwm_oe", int'(pwm_oe), int'(m_st == 1 || m_st == 2));
      chk("R4 ramp", int'(ramp), rr);
      chk("R5 target", int'(target), tg);
      chk("R9 ovp", int'(ovp), int'(m_st == 5));
      chk("R9 lowside", int'(lowside), (m_st == 5) ? (1 << NPH) - 1 : 0);
      chk("R8 lockout", int'(lockout), int'(m_st == 4));
      chk("R10 pgood", int'(pgood), int'(m_st == 2 && !uv && !ov));
    end
  end

  task automatic run(input int n, input int per);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tick = (per > 0) && (k % per == 0);
    end
  endtask

  task automatic set_at_neg();
    @(negedge clk);
  endtask

  initial begin : watchdog
    wait (cycles > 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    run(3, 0);
    rst_n = 1'b1;
    run(2, 0);
    chk("R2 reset pwm_oe", int'(pwm_oe), 0);
    chk("R2 reset ramp", int'(ramp), 0);

    // R1: start needs every condition; missing one holds shutdown
    por = 1; en = 1; fs = 0; vid = 5'd0;
    run(5, 1);
    chk("R1 fs missing", int'(pwm_oe), 0);
    fs = 1;
    run(1, 0);
    run(1, 0);
    chk("R1 start", int'(pwm_oe), 1);

    // R3: tick every other cycle, full ramp
    run(4200, 2);
    chk("R3 ramp complete", int'(pgood), 1);
    chk("R4 full ramp", int'(ramp), 1550 * 7);

    // R10: undervoltage drops pgood only
    uv = 1; run(5, 1);
    chk("R10 uv keeps pwm", int'(pwm_oe), 1);
    uv = 0;

    // R6: reserved code, then restart with a new code
    vid = 5'd31; run(5, 1);
    chk("R6 reserved off", int'(pwm_oe), 0);
    vid = 5'd10; run(1000, 1);
    vid = 5'd30; run(1100, 1);
    chk("R6 vid 30 target", int'(target), 800 * 5);

    // R7: disable with clock stopped, release restarts from zero
    fs = 0; run(10, 0);
    fs = 1; run(3, 0);
    chk("R7 restart at zero", int'(ramp), 0);
    run(100, 1);
    en = 0; run(3, 1);
    en = 1; run(2100, 1);

    // R8: hiccups then lockout
    for (int i = 0; i < RETRIES; i++) begin
      oc = 1; run(1, 1);
      oc = 0; run(30, 1);
    end
    chk("R8 locked", int'(lockout), 1);
    en = 0; run(3, 1); en = 1; run(3, 1);
    chk("R8 lock survives en", int'(lockout), 1);

    // R11: bias loss clears lockout and retry count
    por = 0; run(3, 1);
    por = 1; run(2100, 1);
    oc = 1; run(1, 1); oc = 0; run(30, 1);
    chk("R11 retry cleared", int'(lockout), 0);

    // R9: overvoltage latch
    run(500, 1);
    ov = 1; run(1, 1);
    ov = 0; run(10, 1);
    chk("R9 latched", int'(ovp), 1);
    en = 0; run(5, 1); en = 1; run(5, 1);
    chk("R9 survives en", int'(ovp), 1);
    por = 0; run(2, 1);
    chk("R11 ov cleared", int'(ovp), 0);
    por = 1; run(300, 1);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule